// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial memory. A fast system clock oversamples the bus clock and data lines. Each line passes through a two-flop synchroniser and a short glitch filter. The block then detects start and stop conditions and moves data in 8-bit words, with an acknowledge slot on the ninth clock. The data line is never driven high. The block only pulls it low through an output-enable, and a pad or the testbench turns that enable into an open-drain line.

A write sends a device byte, a word-address byte and one or more data bytes. The data bytes collect in a page buffer and reach the storage array only at the closing stop condition. A self-timed busy window follows, and while it runs the device does not answer its address. A read returns bytes from the internal address, which moves through the whole array. A random read first sets the address with a write that has no data bytes. The array holds from 128 to 2048 bytes. Larger arrays carry their upper word-address bits in the device-byte positions that would otherwise match the strap pins. A write-protect input locks a region of the array, and the size of that region depends on the array size.

Top module: `twe_eeprom_slave`

## Requirements
- R1: Whenever the filtered clock line is high, a falling data line starts a new transfer at the device-byte phase, even in the middle of a byte. A rising data line ends the transfer and returns the block to idle. `standby_o` is high only when the block is idle and no write cycle is running.
- R2: The device byte is acknowledged only if its four upper bits are 1010 and the strap pins match the strap-pin positions in use. Bits 3..1 of the byte face `dev_pins_i[2:0]`. All three positions are used for 128 and 256 bytes, bits 3..2 for 512 bytes, bit 3 for 1024 bytes and none for 2048 bytes. Bit 0 selects read (1) or write (0). A mismatch gets no acknowledge, and the block ignores the bus until the next start.
- R3: For arrays above 256 bytes, the strap-pin positions that are not used carry the word-address bits above bit 7. Address bit 8 is byte bit 1, bit 9 is byte bit 2 and bit 10 is byte bit 3. These bits are taken from the device byte of a write. The next byte gives the low eight address bits.
- R4: Data bytes are acknowledged and stored in a page buffer. At the stop, only the bytes actually received are written, so partial pages are allowed. The page is 8 bytes for arrays of 256 bytes or fewer and 16 bytes for larger arrays.
- R5: Within a write, the in-page offset bits of the address wrap around inside the page, and the page-select bits stay fixed. Bytes beyond one page overwrite the earlier ones.
- R6: When `wp_i` is high at the stop, nothing is written in 128, 256 and 512-byte arrays. In 2048-byte arrays only the upper half is blocked, and 1024-byte arrays are not affected.
- R7: A stop that ends a write with at least one data byte raises `busy_o` for BUSY_CYCLES clocks. While `busy_o` is high the device byte is not acknowledged.
- R8: Read data goes out MSB first. Each bit is set after a falling clock edge and held while the clock is high. After each byte the master acknowledges, and the address then advances through the whole array, wrapping from the last byte to 0.
- R9: A master no-acknowledge after a read byte releases the data line. The block then ignores clocks until the next start or stop.
- R10: A start that arrives before the stop throws away the data bytes of a write. Nothing is written and `busy_o` stays low.
- R11: After reset the data line is released, `busy_o` is low, `standby_o` is high and every array byte reads 8'hFF.
- R12: Pulses on either bus line shorter than FILT_LEN system clocks do not count as bits, starts or stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| dev_pins_i | input | 3 | Strap pins compared against device-byte bits 3..1 |
| wp_i | input | 1 | Write protect, high locks the size-dependent region |
| sda_oe_o | output | 1 | High pulls the data line low |
| busy_o | output | 1 | Self-timed write cycle in progress |
| standby_o | output | 1 | Idle with no write cycle running |

## Verification
The bench runs a 512-byte instance and a 2048-byte instance on separate bus segments.

It writes across a page boundary to check in-page wrap. A design that carried into the page bits would spread the bytes over two pages. It reads across the top of the array to check the wrap to zero, which catches a counter that is held at page size.

It sets and clears write protect on both sizes. A wrong region would write the locked half, or would refuse the lower half of the large array. It also aborts writes with a repeated start and sends short glitches on both lines mid-byte. A design that committed on any start, or that had no filter, would store the wrong values. Finally it addresses the device during the busy window, where an acknowledge is an error.

// File: rtl/twe_pkg.sv
package twe_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_ADDR, PH_WR, PH_RD} phase_t;

  function automatic int word_bits(input int bytes);
    return $clog2(bytes);
  endfunction

  function automatic int page_bytes(input int bytes);
    return (bytes <= 256) ? 8 : 16;
  endfunction

  function automatic int folded_bits(input int bytes);
    return (word_bits(bytes) > 8) ? word_bits(bytes) - 8 : 0;
  endfunction

  function automatic logic [2:0] pin_mask(input int bytes);
    logic [2:0] m;
    m = 3'b111;
    return m << folded_bits(bytes);
  endfunction

  function automatic logic [10:0] join_addr(input logic [2:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic locked(input int bytes, input int addr, input logic wp);
    if (!wp) return 1'b0;
    if (bytes <= 512) return 1'b1;
    if (bytes >= 2048) return addr >= bytes / 2;
    return 1'b0;
  endfunction
endpackage

// File: rtl/twe_deglitch.sv
module twe_deglitch #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(LEN + 1);
  logic [1:0]    sync;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      dout <= 1'b1;
      run  <= '0;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == dout) run <= '0;
      else if (run == CW'(LEN - 1)) begin
        dout <= sync[1];
        run  <= '0;
      end else run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/twe_store.sv
module twe_store
  import twe_pkg::*;
#(
  parameter int BYTES       = 2048,
  parameter int BUSY_CYCLES = 50000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wp,
  input  logic                         wr_pulse,
  input  logic [word_bits(BYTES)-1:0]  wr_addr,
  input  logic [7:0]                   wr_data,
  input  logic                         commit,
  input  logic                         discard,
  input  logic [word_bits(BYTES)-1:0]  rd_addr,
  output logic [7:0]                   rd_data,
  output logic                         busy,
  output logic                         has_data,
  output logic                         wr_any
);
  localparam int AW = word_bits(BYTES);
  localparam int PG = page_bytes(BYTES);
  localparam int PB = $clog2(PG);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [7:0]     mem  [BYTES];
  logic [7:0]     pbuf [PG];
  logic [PG-1:0]  vld, lock_v;
  logic [AW-PB-1:0] base;
  logic [CW-1:0]  timer;

  for (genvar g = 0; g < PG; g++) begin : g_lock
    assign lock_v[g] = locked(BYTES, int'({base, PB'(g)}), wp);
  end

  assign has_data = |vld;
  assign wr_any   = commit & |(vld & ~lock_v);
  assign rd_data  = mem[rd_addr];
  assign busy     = timer != '0;

  always_ff @(posedge clk) begin
    if (wr_pulse) pbuf[wr_addr[PB-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
      vld   <= '0;
      base  <= '0;
      timer <= '0;
    end else begin
      if (commit) begin
        for (int i = 0; i < PG; i++)
          if (vld[i] && !lock_v[i]) mem[{base, PB'(i)}] <= pbuf[i];
      end
      if (commit || discard) vld <= '0;
      else if (wr_pulse) begin
        vld[wr_addr[PB-1:0]] <= 1'b1;
        base <= wr_addr[AW-1:PB];
      end
      if (commit && has_data) timer <= CW'(BUSY_CYCLES);
      else if (busy) timer <= timer - 1'b1;
    end
  end
endmodule

// File: rtl/twe_link.sv
module twe_link
  import twe_pkg::*;
#(
  parameter int BYTES = 2048
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl,
  input  logic                        sda,
  input  logic [2:0]                  dev_pins,
  input  logic                        busy,
  input  logic [7:0]                  rd_data,
  output logic                        sda_oe,
  output logic [word_bits(BYTES)-1:0] addr,
  output logic                        wr_pulse,
  output logic [word_bits(BYTES)-1:0] wr_addr,
  output logic [7:0]                  wr_data,
  output logic                        commit,
  output logic                        discard,
  output logic                        idle,
  output logic                        slv_ack,
  output logic [3:0]                  bit_cnt
);
  localparam int AW = word_bits(BYTES);
  localparam int PB = $clog2(page_bytes(BYTES));
  localparam logic [2:0] PIN_MASK = pin_mask(BYTES);

  phase_t     ph;
  logic       scl_q, sda_q, in_ack;
  logic [7:0] sh, osh;
  logic [2:0] hi;

  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_ev = scl & scl_q & sda_q & ~sda;
  wire stop_ev  = scl & scl_q & ~sda_q & sda;
  wire dev_hit  = (sh[7:4] == 4'b1010) && (((sh[3:1] ^ dev_pins) & PIN_MASK) == 3'b000);

  assign idle = (ph == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; in_ack <= 1'b0; slv_ack <= 1'b0;
      sh <= '0; osh <= '0; hi <= '0; bit_cnt <= '0; sda_oe <= 1'b0; addr <= '0;
      wr_pulse <= 1'b0; wr_addr <= '0; wr_data <= '0; commit <= 1'b0; discard <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      wr_pulse <= 1'b0;
      commit   <= 1'b0;
      discard  <= 1'b0;
      if (start_ev) begin
        ph <= PH_DEV; bit_cnt <= '0; in_ack <= 1'b0; slv_ack <= 1'b0;
        sda_oe <= 1'b0; discard <= 1'b1;
      end else if (stop_ev) begin
        ph <= PH_IDLE; in_ack <= 1'b0; slv_ack <= 1'b0; sda_oe <= 1'b0; commit <= 1'b1;
      end else if (ph != PH_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt != 4'd8) begin
            bit_cnt <= bit_cnt + 1'b1;
            sh <= {sh[6:0], sda};
          end else begin
            bit_cnt <= '0;
            in_ack  <= 1'b1;
            if (ph == PH_RD && !slv_ack) begin
              if (sda) ph <= PH_IDLE;
              else addr <= addr + 1'b1;
            end
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0; slv_ack <= 1'b0; sda_oe <= 1'b0;
            if (ph == PH_RD) begin
              osh    <= rd_data;
              sda_oe <= ~rd_data[7];
            end
          end else if (ph == PH_RD) begin
            if (bit_cnt == 4'd8) sda_oe <= 1'b0;
            else begin
              sda_oe <= ~osh[6];
              osh    <= {osh[6:0], 1'b0};
            end
          end else if (bit_cnt == 4'd8) begin
            case (ph)
              PH_DEV: begin
                if (dev_hit && !busy) begin
                  sda_oe <= 1'b1; slv_ack <= 1'b1;
                  hi <= sh[3:1];
                  ph <= sh[0] ? PH_RD : PH_ADDR;
                end else ph <= PH_IDLE;
              end
              PH_ADDR: begin
                sda_oe <= 1'b1; slv_ack <= 1'b1;
                addr <= AW'(join_addr(hi, sh));
                ph <= PH_WR;
              end
              default: begin
                sda_oe <= 1'b1; slv_ack <= 1'b1;
                wr_pulse <= 1'b1; wr_data <= sh; wr_addr <= addr;
                addr <= {addr[AW-1:PB], addr[PB-1:0] + 1'b1};
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/twe_eeprom_slave.sv
module twe_eeprom_slave
  import twe_pkg::*;
#(
  parameter int MEM_BYTES   = 2048,
  parameter int BUSY_CYCLES = 50000,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_pins_i,
  input  logic       wp_i,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       standby_o
);
  localparam int AW = word_bits(MEM_BYTES);

  logic [1:0]    raw, filt;
  logic          scl_f, sda_f, idle, commit_p, discard_p, wr_pulse, has_data, wr_any, slv_ack;
  logic [AW-1:0] addr, wr_addr;
  logic [7:0]    wr_data, rd_data;
  logic [3:0]    bit_cnt;

  assign raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_line
    twe_deglitch #(.LEN(FILT_LEN)) u_flt (.clk(clk), .rst_n(rst_n), .din(raw[g]), .dout(filt[g]));
  end
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  twe_link #(.BYTES(MEM_BYTES)) u_link (
    .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f), .dev_pins(dev_pins_i),
    .busy(busy_o), .rd_data(rd_data), .sda_oe(sda_oe_o), .addr(addr),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit_p),
    .discard(discard_p), .idle(idle), .slv_ack(slv_ack), .bit_cnt(bit_cnt)
  );

  twe_store #(.BYTES(MEM_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .wp(wp_i), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit_p), .discard(discard_p), .rd_addr(addr),
    .rd_data(rd_data), .busy(busy_o), .has_data(has_data), .wr_any(wr_any)
  );

  assign standby_o = idle & ~busy_o;
endmodule

// File: rtl/twe_eeprom_slave_chk.sv
module twe_eeprom_slave_chk #(
  parameter int BYTES = 2048
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_oe_o,
  input logic       busy_o,
  input logic       standby_o,
  input logic       commit_p,
  input logic       has_data,
  input logic       wr_any,
  input logic       wp_i,
  input logic       slv_ack,
  input logic [3:0] bit_cnt
);
  localparam bit FULL_LOCK = (BYTES <= 512);

  AST_OE_MOVES_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !$past(scl_f)); // R8
  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_p && has_data) |=> busy_o); // R7
  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slv_ack) |-> !$past(busy_o)); // R7
  AST_LOCKED_ARRAY_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |-> !(wp_i && FULL_LOCK)); // R6
  AST_STANDBY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> !sda_oe_o); // R11
  AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd8); // R2
endmodule

bind twe_eeprom_slave twe_eeprom_slave_chk #(.BYTES(MEM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
  .standby_o(standby_o), .commit_p(commit_p), .has_data(has_data), .wr_any(wr_any),
  .wp_i(wp_i), .slv_ack(slv_ack), .bit_cnt(bit_cnt)
);

// File: tb/twe_eeprom_slave_test.sv
module twe_eeprom_slave_test;
  localparam int CLK_P = 10;
  localparam int H     = 16;
  localparam int BUSY  = 1200;
  localparam int WD    = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, sel = 1'b0, wp_a = 1'b0, wp_b = 1'b0;
  logic oe_a, oe_b, busy_a, busy_b, sb_a, sb_b;
  logic scl_a, scl_b, line_a, line_b, line;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] ma [512];
  logic [7:0] mb [2048];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always #(CLK_P/2) clk = ~clk;

  assign scl_a  = sel ? 1'b1 : scl_m;
  assign scl_b  = sel ? scl_m : 1'b1;
  assign line_a = (sel ? 1'b1 : sda_m) & ~oe_a;
  assign line_b = (sel ? sda_m : 1'b1) & ~oe_b;
  assign line   = sel ? line_b : line_a;

  twe_eeprom_slave #(.MEM_BYTES(512), .BUSY_CYCLES(BUSY), .FILT_LEN(4)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_a), .sda_i(line_a), .dev_pins_i(3'b110),
    .wp_i(wp_a), .sda_oe_o(oe_a), .busy_o(busy_a), .standby_o(sb_a));
  twe_eeprom_slave #(.MEM_BYTES(2048), .BUSY_CYCLES(BUSY), .FILT_LEN(4)) uut_big (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_b), .sda_i(line_b), .dev_pins_i(3'b000),
    .wp_i(wp_b), .sda_oe_o(oe_b), .busy_o(busy_b), .standby_o(sb_b));

  function automatic int size_of(); return sel ? 2048 : 512; endfunction
  function automatic int page_of(); return (size_of() < 512) ? 8 : 16; endfunction
  function automatic logic [7:0] dev(input int a, input logic rw);
    return sel ? {4'hA, 3'(a >> 8), rw} : {4'hA, 2'b11, 1'(a >> 8), rw};
  endfunction
  function automatic bit lock_exp(input int a);
    return sel ? (wp_b && a >= 1024) : wp_a;
  endfunction
  function automatic int mget(input int a); return sel ? mb[a] : ma[a]; endfunction

  task automatic wclk(input int n); repeat (n) @(negedge clk); endtask
  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_c();
    wclk(4); sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H); sda_m = 1'b0; wclk(H); scl_m = 1'b0;
  endtask
  task automatic stop_c();
    wclk(4); sda_m = 1'b0; wclk(H); scl_m = 1'b1; wclk(H); sda_m = 1'b1; wclk(H);
  endtask
  // gl: 1 = short data pulse while clock high, 2 = short clock pulse while low
  task automatic bit_out(input logic b, input int gl);
    wclk(4); sda_m = b;
    if (gl == 2) begin wclk(4); scl_m = 1'b1; wclk(2); scl_m = 1'b0; wclk(H - 6); end
    else wclk(H);
    scl_m = 1'b1;
    if (gl == 1) begin wclk(H/2); sda_m = ~b; wclk(2); sda_m = b; wclk(H/2 - 2); end
    else wclk(H);
    scl_m = 1'b0;
  endtask
  task automatic bit_in(output logic v);
    wclk(4); sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H/2); v = line; wclk(H - H/2); scl_m = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack, input int gpos = -1, input int gk = 0);
    logic v;
    for (int k = 0; k < 8; k++) bit_out(b[7-k], (k == gpos) ? gk : 0);
    bit_in(v);
    ack = ~v;
  endtask
  task automatic recv_byte(output logic [7:0] d, input logic nack);
    logic v;
    d = '0;
    for (int k = 0; k < 8; k++) begin bit_in(v); d = {d[6:0], v}; end
    bit_out(nack, 0);
  endtask

  task automatic wr_txn(input int a, input int n, input bit do_stop);
    logic ack;
    int pg, off;
    start_c();
    send_byte(dev(a, 1'b0), ack); chk("R2 device ack on write", ack, 1);
    send_byte(a[7:0], ack);       chk("R3 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin send_byte(wbuf[k], ack); chk("R4 data ack", ack, 1); end
    if (do_stop) begin
      stop_c();
      chk("R7 busy after stop", sel ? busy_b : busy_a, n > 0 ? 1 : 0);
      pg = page_of();
      for (int k = 0; k < n; k++) begin
        off = (a % pg + k) % pg;
        if (!lock_exp(a - a % pg + off)) begin
          if (sel) mb[a - a % pg + off] = wbuf[k]; else ma[a - a % pg + off] = wbuf[k];
        end
      end
    end
  endtask

  task automatic rd_txn(input int a, input int n);
    logic ack;
    start_c();
    send_byte(dev(a, 1'b0), ack); chk("R2 device ack before read", ack, 1);
    send_byte(a[7:0], ack);       chk("R3 address ack before read", ack, 1);
    start_c();
    send_byte(dev(a, 1'b1), ack); chk("R8 device ack on read", ack, 1);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k == n - 1);
    wclk(H);
    chk("R9 line released after nack", line, 1);
    stop_c();
  endtask

  task automatic rd_check(input string req, input int a, input int n);
    rd_txn(a, n);
    for (int k = 0; k < n; k++) chk(req, rbuf[k], mget((a + k) % size_of()));
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    int a, n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) ma[i] = 8'hFF;
    for (int i = 0; i < 2048; i++) mb[i] = 8'hFF;
    wclk(5); rst_n = 1'b1; wclk(5);

    // R11 reset state
    chk("R11 oe after reset", oe_a, 0);
    chk("R11 busy after reset", busy_a, 0);
    chk("R11 standby after reset", sb_a, 1);
    chk("R11 large standby after reset", sb_b, 1);

    // R2 address mismatches
    start_c(); send_byte(8'b1010_0100, ack); chk("R2 wrong pins nack", ack, 0); stop_c();
    start_c(); send_byte(8'b1011_1100, ack); chk("R2 wrong type nack", ack, 0); stop_c();

    // R1 standby tracks the transfer
    start_c(); send_byte(dev(0, 1'b0), ack);
    chk("R1 standby low in transfer", sb_a, 0);
    stop_c(); chk("R1 standby back after stop", sb_a, 1);

    // R4 R3 R7 partial page in upper region, busy window
    for (int k = 0; k < 5; k++) wbuf[k] = 8'(8'h30 + k);
    wr_txn(32'h1F3, 5, 1'b1);
    start_c(); send_byte(dev(0, 1'b0), ack); chk("R7 nack while busy", ack, 0); stop_c();
    wclk(BUSY + 50);
    chk("R7 busy ends", busy_a, 0);
    rd_check("R4 partial page data", 32'h1F2, 7);
    rd_check("R3 folded bit separates halves", 32'h0F3, 1);

    // R5 page wrap with 20 bytes
    for (int k = 0; k < 20; k++) wbuf[k] = 8'($urandom);
    wr_txn(32'h00A, 20, 1'b1); wclk(BUSY + 50);
    rd_check("R5 page wrap", 32'h000, 16);
    rd_check("R5 next page untouched", 32'h010, 1);

    // R8 sequential read across top of array
    rd_check("R8 read wraps to zero", 32'h1FE, 4);

    // R9 ignores clocks after master nack
    rd_txn(32'h1F3, 1);
    start_c(); send_byte(dev(32'h1F3, 1'b1), ack);
    recv_byte(rbuf[0], 1'b1);
    for (int k = 0; k < 9; k++) begin
      logic v;
      bit_in(v);
      chk("R9 silent after nack", v, 1);
    end
    stop_c();

    // R10 repeated start discards a write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_txn(32'h070, 2, 1'b0);
    rd_check("R10 aborted write not stored", 32'h070, 2);
    chk("R10 no busy after abort", busy_a, 0);

    // R1 start in the middle of a byte
    start_c(); bit_out(1'b1, 0); bit_out(1'b0, 0); bit_out(1'b1, 0);
    rd_check("R1 mid-byte start recovers", 32'h1F3, 2);

    // R12 glitches on both lines inside a data byte
    start_c();
    send_byte(dev(32'h060, 1'b0), ack); send_byte(8'h60, ack);
    send_byte(8'h5A, ack, 1, 1); chk("R12 ack after data glitch", ack, 1);
    send_byte(8'hC3, ack, 3, 2); chk("R12 ack after clock glitch", ack, 1);
    stop_c(); ma[32'h060] = 8'h5A; ma[32'h061] = 8'hC3; wclk(BUSY + 50);
    rd_check("R12 glitch-free data", 32'h060, 2);

    // R6 full lock on 512 bytes
    wp_a = 1'b1;
    wbuf[0] = 8'hAA; wbuf[1] = 8'h55; wbuf[2] = 8'h0F;
    wr_txn(32'h040, 3, 1'b1); wclk(BUSY + 50);
    wp_a = 1'b0;
    rd_check("R6 locked small array", 32'h040, 3);

    // R6 R3 upper-half lock on 2048 bytes
    sel = 1'b1; wclk(20);
    wp_b = 1'b1;
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    wr_txn(32'h3F0, 2, 1'b1); wclk(BUSY + 50);
    wr_txn(32'h5F0, 2, 1'b1); wclk(BUSY + 50);
    wp_b = 1'b0;
    rd_check("R6 lower half writable", 32'h3F0, 2);
    rd_check("R6 upper half locked", 32'h5F0, 2);
    wbuf[0] = 8'h9C; wbuf[1] = 8'hE1;
    wr_txn(32'h7F8, 2, 1'b1); wclk(BUSY + 50);
    rd_check("R3 three folded bits", 32'h7F8, 2);
    rd_check("R3 other high page untouched", 32'h3F8, 1);

    // random writes then readback on the small array
    sel = 1'b0; wclk(20);
    for (int it = 0; it < 6; it++) begin
      a = int'($urandom % 512);
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_txn(a, n, 1'b1); wclk(BUSY + 50);
      rd_check("R4 random write readback", a, n);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule